// File: doc/BRIEF.md
# Clock Controller Register Bank

This block holds the configuration state of a clock control unit: one operating-mode register, two post-divider registers, a main and an auxiliary PLL control register, three clock-gating registers and one power-management register. A host reaches them through a plain 32-bit word bus with a valid, a write flag, a word address, write data and read data, covering a 4 KB byte window. No clocks are generated here. Downstream logic reads the stored values and recomputes frequencies.

Each writable register applies its own write mask. Bits outside the mask are stored as zero. The mode register also forces one configurable bit to one on every write. The power-management register reads back its reset value and ignores writes. One fixed location returns a constant. When a write lands in a register that changes clock frequencies (the mode, a divider or a PLL register), the block raises a one-cycle recompute strobe so that consumers can refresh their derived rates. Gating-register writes do not raise the strobe.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset the registers read back as follows. Mode (word 0) reads 0x074b0b7b. Divider A (word 1) reads 0xff870b48 and divider B (word 2) reads 0x49fcfe7f. Main PLL (word 4) reads 0x04001800 and auxiliary PLL (word 6) reads 0x04043001. Gates 0..2 (words 8, 9, 10) read 0xffffffff. Power management (word 23) reads 0x80209828.
- R2: A write to word 0 stores the data ANDed with 0x3b6fdfff, with bit FORCE_BIT (default 26) set to one.
- R3: A write to word 1 stores the data ANDed with 0xff9f3fff. A write to word 2 stores the full word.
- R4: A write to word 4 or word 6 stores the data ANDed with 0xbfff3fff.
- R5: Writes to words 8, 9 and 10 store the full word, each into its own gating register.
- R6: Writes to word 23 have no effect, and word 23 always reads 0x80209828.
- R7: A read of word 18 returns 0x00004040. A write to word 18 does not change that value. Reads of any other unlisted word return 0, and writes to such words store nothing.
- R8: An accepted write to word 0, 1, 2, 4 or 6 sets recalc_pulse high in the following cycle only, unless another such write follows at once.
- R9: recalc_pulse stays low after reads, after writes to words 8, 9, 10, 18, 23 or any unlisted word, and after cycles with bus_valid low. A cycle with bus_valid low changes no register.
- R10: bus_rdata is 0 in every cycle that is not a read (bus_valid high and bus_write low). In a read cycle it shows the addressed value in that same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W-2 (10) | Word address (byte address bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 outside reads |
| recalc_pulse | output | 1 | One-cycle strobe after a frequency-affecting write |

## Verification
The assertions check on every cycle that the read data is idle-zero outside reads, that the mode register always shows its forced bit, and that the constant and power-management words never change. They also check that the strobe follows frequency-affecting writes and never follows gating writes or non-write cycles. Only the bench scenarios can show the exact masked values after specific write patterns, that each gating register is separate from its neighbours, that unlisted words discard data, and the complete set of reset values.

// File: rtl/clkctl_pkg.sv
// Package: shared layout of the clock controller register bank.
// Holds the register count, word offsets, reset values, write masks and the
// per-register class bits. Entry index i describes the same register in
// every table.
package clkctl_pkg;

    localparam int NREG = 9;
    localparam int DW   = 32;

    // Index of each stored register in the tables below
    typedef enum int {
        IDX_MODE = 0,
        IDX_DIVA = 1,
        IDX_DIVB = 2,
        IDX_PLLM = 3,
        IDX_PLLA = 4,
        IDX_GAT0 = 5,
        IDX_GAT1 = 6,
        IDX_GAT2 = 7,
        IDX_PWR  = 8
    } reg_idx_e;

    localparam int unsigned REG_OFF [NREG] = '{0, 1, 2, 4, 6, 8, 9, 10, 23};

    localparam logic [DW-1:0] REG_RST [NREG] = '{
        32'h074b0b7b, 32'hff870b48, 32'h49fcfe7f,
        32'h04001800, 32'h04043001,
        32'hffffffff, 32'hffffffff, 32'hffffffff,
        32'h80209828
    };

    localparam logic [DW-1:0] REG_MASK [NREG] = '{
        32'h3b6fdfff, 32'hff9f3fff, 32'hffffffff,
        32'hbfff3fff, 32'hbfff3fff,
        32'hffffffff, 32'hffffffff, 32'hffffffff,
        32'h00000000
    };

    // Registers whose writes request frequency recomputation
    localparam logic [NREG-1:0] REG_KICK = 9'b0_0001_1111;
    // Registers that accept writes at all
    localparam logic [NREG-1:0] REG_WREN = 9'b0_1111_1111;

    // Fixed read-only location
    localparam int unsigned CONST_OFF = 18;
    localparam logic [DW-1:0] CONST_VAL = 32'h00004040;

endpackage

// File: rtl/clkctl_addr_dec.sv
// Module: address decoder of the register bank.
// Turns a word address plus valid/write into one-hot register hits, write
// enables, a constant-location hit and the recompute request.
// Assumes word offsets in clkctl_pkg are distinct.
module clkctl_addr_dec
    import clkctl_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              valid,
    input  logic              write,
    input  logic [WORD_W-1:0] word,
    output logic [NREG-1:0]   hit,
    output logic [NREG-1:0]   wr_sel,
    output logic              const_hit,
    output logic              kick
);

    localparam int PAD_W = 32 - WORD_W;

    logic [31:0] word_ext;
    assign word_ext = {{PAD_W{1'b0}}, word};

    // Compare the word address against every register offset
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            hit[i] = (word_ext == REG_OFF[i]);
        end
    end

    // Qualify hits into write enables for writable registers only
    assign wr_sel    = (valid && write) ? (hit & REG_WREN) : '0;
    assign const_hit = (word_ext == CONST_OFF);
    // Request recompute when a write lands in a frequency-affecting register
    assign kick      = valid && write && |(hit & REG_KICK);

endmodule

// File: rtl/clkctl_field_reg.sv
// Module: one masked configuration register.
// Loads RST_VAL on reset; on a write stores (data & MASK) | FORCE_SET.
// Bits outside MASK become zero on a write, as the bank requires.
module clkctl_field_reg #(
    parameter int          W         = 32,
    parameter logic [W-1:0] RST_VAL  = '0,
    parameter logic [W-1:0] MASK     = '1,
    parameter logic [W-1:0] FORCE_SET = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Hold the register, reload on reset, take masked data on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (we) begin
            q <= (wdata & MASK) | FORCE_SET;
        end
    end

endmodule

// File: rtl/clkctl_rd_mux.sv
// Module: read-data selector.
// ORs together the register values whose hit bit is set, plus the constant
// location. Gated to zero outside read cycles. Assumes hits are one-hot or
// zero.
module clkctl_rd_mux
    import clkctl_pkg::*;
(
    input  logic                     rd_en,
    input  logic [NREG-1:0]          hit,
    input  logic                     const_hit,
    input  logic [NREG-1:0][DW-1:0]  regs,
    output logic [DW-1:0]            rdata
);

    // AND-OR selection of the addressed value
    always_comb begin
        rdata = const_hit ? CONST_VAL : '0;
        for (int i = 0; i < NREG; i++) begin
            rdata = rdata | (hit[i] ? regs[i] : '0);
        end
        if (!rd_en) begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/clkctl_regbank.sv
// Module: clock controller register bank (top).
// Word-addressed 32-bit register file with per-register write masks, one
// forced mode bit, a read-only constant location and a registered recompute
// strobe. bus_addr carries byte-address bits [ADDR_W-1:2]. Reads are
// combinational; writes take effect at the clock edge.
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int FORCE_BIT = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-3:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              recalc_pulse
);

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [DW-1:0] FORCE_MASK = DW'(1) << FORCE_BIT;

    logic [NREG-1:0]         hit;
    logic [NREG-1:0]         wr_sel;
    logic                    const_hit;
    logic                    kick;
    logic [NREG-1:0][DW-1:0] regs;

    clkctl_addr_dec #(.WORD_W(WORD_W)) u_dec (
        .valid     (bus_valid),
        .write     (bus_write),
        .word      (bus_addr),
        .hit       (hit),
        .wr_sel    (wr_sel),
        .const_hit (const_hit),
        .kick      (kick)
    );

    // One masked register per table entry; only the mode entry forces a bit
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] FSET = (g == IDX_MODE) ? FORCE_MASK : '0;
        clkctl_field_reg #(
            .W         (DW),
            .RST_VAL   (REG_RST[g]),
            .MASK      (REG_MASK[g]),
            .FORCE_SET (FSET)
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_sel[g]),
            .wdata (bus_wdata),
            .q     (regs[g])
        );
    end

    clkctl_rd_mux u_mux (
        .rd_en     (bus_valid && !bus_write),
        .hit       (hit),
        .const_hit (const_hit),
        .regs      (regs),
        .rdata     (bus_rdata)
    );

    // Register the recompute request into a one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recalc_pulse <= 1'b0;
        end else begin
            recalc_pulse <= kick;
        end
    end

endmodule

// File: rtl/clkctl_regbank_chk.sv
// Module: assertion checker for clkctl_regbank, bound to every instance.
// Observes only the top-level ports.
module clkctl_regbank_chk #(
    parameter int ADDR_W    = 12,
    parameter int FORCE_BIT = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-3:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              recalc_pulse
);

    localparam int WORD_W = ADDR_W - 2;

    logic rd, wr, wr_freq, wr_gate;
    assign rd      = bus_valid && !bus_write;
    assign wr      = bus_valid && bus_write;
    assign wr_freq = wr && (bus_addr == WORD_W'(0) || bus_addr == WORD_W'(1) ||
                            bus_addr == WORD_W'(2) || bus_addr == WORD_W'(4) ||
                            bus_addr == WORD_W'(6));
    assign wr_gate = wr && (bus_addr == WORD_W'(8) || bus_addr == WORD_W'(9) ||
                            bus_addr == WORD_W'(10));

    // R8: frequency-affecting write is followed by the strobe
    p_pulse_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_freq |=> recalc_pulse);

    // R9: gating writes never raise the strobe
    p_gate_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gate |=> !recalc_pulse);

    // R9: the strobe only follows a write cycle
    p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        recalc_pulse |-> $past(wr));

    // R10: read data is zero outside read cycles
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> bus_rdata == 32'h0);

    // R2: mode register always shows the forced bit
    p_mode_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == WORD_W'(0)) |-> bus_rdata[FORCE_BIT]);

    // R7: constant location never changes
    p_const_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == WORD_W'(18)) |-> bus_rdata == 32'h00004040);

    // R6: power-management word never changes
    p_pwr_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == WORD_W'(23)) |-> bus_rdata == 32'h80209828);

endmodule

bind clkctl_regbank clkctl_regbank_chk #(
    .ADDR_W    (ADDR_W),
    .FORCE_BIT (FORCE_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .recalc_pulse (recalc_pulse)
);

// File: tb/clkctl_regbank_bench.sv
// Directed bench for clkctl_regbank: one task per scenario.
module clkctl_regbank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-3:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          recalc_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkctl_regbank u_clkctl_regbank (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .recalc_pulse (recalc_pulse)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Write one word; returns strobe value in the following cycle
    task automatic wr(int word, logic [31:0] data, output logic pulse);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = (AW-2)'(word); bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        #1 pulse = recalc_pulse;
    endtask

    // Read one word combinationally within the same cycle
    task automatic rd(int word, output logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = (AW-2)'(word);
        #1 data = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic t_reset_r1();
        logic [31:0] d;
        int offs [9] = '{0, 1, 2, 4, 6, 8, 9, 10, 23};
        logic [31:0] exp [9] = '{32'h074b0b7b, 32'hff870b48, 32'h49fcfe7f,
            32'h04001800, 32'h04043001, 32'hffffffff, 32'hffffffff,
            32'hffffffff, 32'h80209828};
        check("R1 pulse low after reset", {31'b0, recalc_pulse}, 0);
        for (int i = 0; i < 9; i++) begin
            rd(offs[i], d);
            check($sformatf("R1 reset word %0d", offs[i]), d, exp[i]);
        end
    endtask

    task automatic t_mode_r2();
        logic [31:0] d; logic p;
        wr(0, 32'hffffffff, p);
        check("R8 pulse after mode write", {31'b0, p}, 1);
        rd(0, d); check("R2 mode all ones", d, 32'h3f6fdfff);
        wr(0, 32'h0, p);
        rd(0, d); check("R2 mode zero keeps forced bit", d, 32'h04000000);
    endtask

    task automatic t_div_r3();
        logic [31:0] d; logic p;
        wr(1, 32'hffffffff, p);
        check("R8 pulse after divider A write", {31'b0, p}, 1);
        rd(1, d); check("R3 divider A mask", d, 32'hff9f3fff);
        wr(2, 32'h12345678, p);
        check("R8 pulse after divider B write", {31'b0, p}, 1);
        rd(2, d); check("R3 divider B full word", d, 32'h12345678);
    endtask

    task automatic t_pll_r4();
        logic [31:0] d; logic p;
        wr(4, 32'hffffffff, p);
        check("R8 pulse after main PLL write", {31'b0, p}, 1);
        wr(6, 32'h55555555, p);
        check("R8 pulse after aux PLL write", {31'b0, p}, 1);
        rd(4, d); check("R4 main PLL mask", d, 32'hbfff3fff);
        rd(6, d); check("R4 aux PLL mask", d, 32'h15551555);
    endtask

    task automatic t_gate_r5();
        logic [31:0] d; logic p;
        wr(8, 32'h11111111, p);
        check("R9 no pulse after gate 0 write", {31'b0, p}, 0);
        wr(9, 32'h22222222, p);
        check("R9 no pulse after gate 1 write", {31'b0, p}, 0);
        wr(10, 32'h33333333, p);
        check("R9 no pulse after gate 2 write", {31'b0, p}, 0);
        rd(8, d);  check("R5 gate 0", d, 32'h11111111);
        rd(9, d);  check("R5 gate 1", d, 32'h22222222);
        rd(10, d); check("R5 gate 2", d, 32'h33333333);
    endtask

    task automatic t_pwr_r6();
        logic [31:0] d; logic p;
        wr(23, 32'h00000000, p);
        check("R9 no pulse after power write", {31'b0, p}, 0);
        rd(23, d); check("R6 power ignores write", d, 32'h80209828);
    endtask

    task automatic t_const_r7();
        logic [31:0] d; logic p;
        rd(18, d); check("R7 constant word", d, 32'h00004040);
        wr(18, 32'hdeadbeef, p);
        check("R9 no pulse after constant write", {31'b0, p}, 0);
        rd(18, d); check("R7 constant after write", d, 32'h00004040);
        wr(3, 32'hcafef00d, p);
        check("R9 no pulse after unlisted write", {31'b0, p}, 0);
        rd(3, d);    check("R7 unlisted word 3", d, 0);
        rd(7, d);    check("R7 unlisted word 7", d, 0);
        rd(24, d);   check("R7 unlisted word 24", d, 0);
        rd(1023, d); check("R7 unlisted word 1023", d, 0);
    endtask

    task automatic t_pulse_r8();
        logic p;
        wr(2, 32'h0, p);
        check("R8 pulse high", {31'b0, p}, 1);
        @(negedge clk); #1;
        check("R8 pulse lasts one cycle", {31'b0, recalc_pulse}, 0);
    endtask

    task automatic t_novalid_r9();
        logic [31:0] d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b1; bus_addr = 10'd8; bus_wdata = 32'h0;
        @(negedge clk); #1;
        check("R9 no pulse without valid", {31'b0, recalc_pulse}, 0);
        bus_write = 1'b0;
        rd(8, d); check("R9 gate 0 unchanged without valid", d, 32'h11111111);
    endtask

    task automatic t_idle_r10();
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = 10'd18;
        #1 check("R10 rdata zero when idle", bus_rdata, 0);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 10'd9; bus_wdata = 32'h22222222;
        #1 check("R10 rdata zero during write", bus_rdata, 0);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset_r1();
        t_mode_r2();
        t_div_r3();
        t_pll_r4();
        t_gate_r5();
        t_pwr_r6();
        t_const_r7();
        t_pulse_r8();
        t_novalid_r9();
        t_idle_r10();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule